// File: doc/BRIEF.md
# Paired Lookup-Table Logic Cell

This block is a small programmable glue-logic unit. It holds two lookup-table cells. Each cell reads three single-bit inputs, and each input can be switched off on its own. The cell forms a 3-bit index from its inputs and picks one bit of an 8-bit truth table, so the cell can compute any Boolean function of up to three variables. After the table, the result can be resynchronised to the clock, or resynchronised and then filtered against one-cycle glitches. It can also be turned into a single-cycle pulse on a chosen edge.

A sequencer is shared by the pair. The lower cell drives its first input and the upper cell drives its second input. The sequencer can pass the lower result straight through, or it can act as a D flip-flop, a JK flip-flop, a D latch or an SR latch. Its result replaces the lower cell's output, and the upper cell's output always appears unchanged. The sequencer is a two-state machine with states ST_LOW and ST_HIGH:

- In the flip-flop modes its state changes only on a clock edge.
- In the latch modes the output is transparent within the cycle, and the state records that output at every edge.

Software programs the block through a byte-wide write port. A global enable, when low, forces both outputs to zero and clears every stage and the sequencer state.

Top module: `lut_pair_cell`

## Requirements
- R1: With the block enabled, the sequencer in mode 0 (pass-through), and neither conditioning nor edge detection selected, the lower output equals bit {in2,in1,in0} of that cell's truth table in the same cycle. The lower cell's inputs are cell_in[2:0] and the upper cell's inputs are cell_in[5:3]. The truth tables are written at address 0 (lower cell) and address 1 (upper cell).
- R2: Each cell has a control byte, at address 2 (lower) or address 3 (upper). Bits [2:0] of that byte are input enables, one per input; an input whose enable is 0 reads as 0 when the index is formed.
- R3: Control bits [4:3] = 1 select the synchroniser. A change at the table output reaches the cell output after exactly two rising clock edges.
- R4: Control bits [4:3] = 2 select the filter. A stable change reaches the output after exactly five rising edges, and a table-output pulse lasting one cycle never reaches the output.
- R5: Control bit 5 enables the edge detector. It emits a one-cycle pulse when the conditioned value rises, or when it falls if control bit 6 is 1.
- R6: The sequencer mode is held in bits [2:0] of address 4. In mode 1 (D flip-flop) the lower output takes the lower cell's result at each edge where the upper cell's result is 1, and holds otherwise.
- R7: In mode 2 (JK flip-flop) the lower cell is J and the upper cell is K. At each edge the state is set by 10, cleared by 01, toggled by 11 and held by 00.
- R8: In mode 3 (D latch) the lower output follows the lower cell within the same cycle while the upper cell is 1, and holds its last value while the upper cell is 0.
- R9: In mode 4 (SR latch) the lower cell sets and the upper cell resets. Reset wins when both are 1, and the output is held when both are 0.
- R10: While glb_en is low both outputs are 0, and on re-enable the sequencer starts from state 0.
- R11: cell_out[1] always carries the upper cell's own result, whatever the sequencer mode.
- R12: After reset every configuration register is 0 and both outputs are 0. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable; low clears and silences the block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cell_in | input | 6 | Cell inputs: [2:0] lower cell, [5:3] upper cell |
| cell_out | output | 2 | [0] sequencer/lower result, [1] upper result |

## Verification
A corrupted sequencer state shows on cell_out[0] in the cycle it arises:

- In the latch modes it shows at once whenever both cell results are 0.
- In the flip-flop modes it shows one edge after the bad transition.

A wrong stage in a conditioning pipeline shows only as a late, early or missing output change, up to five edges after the table output moves. For that reason the directed tests check the output both one edge before and at the edge of the expected change. A stuck previous-value register in the edge detector shows either as a pulse that lasts two cycles or as no pulse at all, and both are visible at the next edge.

// File: rtl/lut_pkg.sv
`timescale 1ns/1ps
package lut_pkg;
    localparam int LUT_IN = 3;
    localparam int TT_W   = 1 << LUT_IN;
    localparam int SYNC_N = 2;
    localparam int FILT_N = 2;

    typedef enum logic [1:0] {
        COND_NONE = 2'd0,
        COND_SYNC = 2'd1,
        COND_FILT = 2'd2
    } cond_t;

    typedef struct packed {
        logic              edge_fall;
        logic              edge_on;
        cond_t             cond;
        logic [LUT_IN-1:0] in_en;
    } cell_ctl_t;

    typedef enum logic [2:0] {
        SEQ_OFF  = 3'd0,
        SEQ_DFF  = 3'd1,
        SEQ_JK   = 3'd2,
        SEQ_DLAT = 3'd3,
        SEQ_SR   = 3'd4
    } seq_mode_t;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } seq_st_t;
endpackage

// File: rtl/lut_cell.sv
`timescale 1ns/1ps
module lut_cell
    import lut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [TT_W-1:0]   tt,
    input  cell_ctl_t         ctl,
    input  logic [LUT_IN-1:0] din,
    output logic              res,
    output logic              edge_pls
);
    localparam int PIPE_N = SYNC_N + FILT_N;

    logic [LUT_IN-1:0] idx;
    logic              raw;
    logic [PIPE_N-1:0] pipe_q;
    logic              filt_q;
    logic              prev_q;
    logic              cond_v;
    logic              agree;
    logic              pls;

    assign idx   = din & ctl.in_en;
    assign raw   = tt[idx];
    assign agree = (&pipe_q[PIPE_N-1:SYNC_N]) | ~(|pipe_q[PIPE_N-1:SYNC_N]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
            filt_q <= 1'b0;
            prev_q <= 1'b0;
        end else if (!en) begin
            pipe_q <= '0;
            filt_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            pipe_q <= {pipe_q[PIPE_N-2:0], raw};
            if (agree) filt_q <= pipe_q[PIPE_N-1];
            prev_q <= cond_v;
        end
    end

    always_comb begin
        unique case (ctl.cond)
            COND_SYNC: cond_v = pipe_q[SYNC_N-1];
            COND_FILT: cond_v = filt_q;
            default:   cond_v = raw;
        endcase
    end

    assign pls      = ctl.edge_fall ? (~cond_v & prev_q) : (cond_v & ~prev_q);
    assign edge_pls = en & ctl.edge_on & pls;
    assign res      = en & (ctl.edge_on ? pls : cond_v);
endmodule

// File: rtl/lut_seq.sv
`timescale 1ns/1ps
module lut_seq
    import lut_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  seq_mode_t mode,
    input  logic      a,
    input  logic      b,
    output logic      y
);
    seq_st_t st_q, st_nx;
    logic    q;
    logic    lat;

    assign q = (st_q == ST_HIGH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st_q <= ST_LOW;
        else if (!en) st_q <= ST_LOW;
        else          st_q <= st_nx;
    end

    always_comb begin
        unique case (mode)
            SEQ_DLAT: lat = b ? a : q;
            SEQ_SR:   lat = b ? 1'b0 : (a ? 1'b1 : q);
            default:  lat = q;
        endcase
    end

    always_comb begin
        st_nx = st_q;
        unique case (mode)
            SEQ_DFF: if (b) st_nx = a ? ST_HIGH : ST_LOW;
            SEQ_JK: begin
                unique case ({a, b})
                    2'b10:   st_nx = ST_HIGH;
                    2'b01:   st_nx = ST_LOW;
                    2'b11:   st_nx = q ? ST_LOW : ST_HIGH;
                    default: st_nx = st_q;
                endcase
            end
            SEQ_DLAT, SEQ_SR: st_nx = lat ? ST_HIGH : ST_LOW;
            default: st_nx = ST_LOW;
        endcase
    end

    always_comb begin
        unique case (mode)
            SEQ_DFF, SEQ_JK:  y = q;
            SEQ_DLAT, SEQ_SR: y = lat;
            default:          y = a;
        endcase
    end
endmodule

// File: rtl/lut_pair_cell.sv
`timescale 1ns/1ps
module lut_pair_cell
    import lut_pkg::*;
#(
    parameter int CFG_AW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                glb_en,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [TT_W-1:0]     cfg_wdata,
    input  logic [2*LUT_IN-1:0] cell_in,
    output logic [1:0]          cell_out
);
    localparam int NCELL   = 2;
    localparam int A_TT    = 0;
    localparam int A_CTL   = A_TT + NCELL;
    localparam int A_MODE  = A_CTL + NCELL;
    localparam int CTL_W   = $bits(cell_ctl_t);
    localparam int MODE_W  = $bits(seq_mode_t);

    logic [TT_W-1:0]   tt_q  [NCELL];
    logic [CTL_W-1:0]  ctl_q [NCELL];
    logic [MODE_W-1:0] mode_q;
    logic [NCELL-1:0]  cell_res;
    logic [NCELL-1:0]  edge_pls;
    logic              seq_y;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      mode_q <= '0;
        else if (cfg_we && cfg_addr == CFG_AW'(A_MODE))  mode_q <= cfg_wdata[MODE_W-1:0];
    end

    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tt_q[g]  <= '0;
                ctl_q[g] <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == CFG_AW'(A_TT + g))  tt_q[g]  <= cfg_wdata;
                if (cfg_addr == CFG_AW'(A_CTL + g)) ctl_q[g] <= cfg_wdata[CTL_W-1:0];
            end
        end

        lut_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (glb_en),
            .tt       (tt_q[g]),
            .ctl      (cell_ctl_t'(ctl_q[g])),
            .din      (cell_in[g*LUT_IN +: LUT_IN]),
            .res      (cell_res[g]),
            .edge_pls (edge_pls[g])
        );
    end

    lut_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (glb_en),
        .mode  (seq_mode_t'(mode_q)),
        .a     (cell_res[0]),
        .b     (cell_res[1]),
        .y     (seq_y)
    );

    assign cell_out = glb_en ? {cell_res[1], seq_y} : 2'b00;
endmodule

// File: rtl/lut_pair_chk.sv
`timescale 1ns/1ps
module lut_pair_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       glb_en,
    input logic       cfg_we,
    input logic [2:0] mode,
    input logic [1:0] res,
    input logic [1:0] edge_pls,
    input logic [1:0] cell_out
);
    p_off_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> (cell_out == 2'b00));

    p_sr_reset_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && mode == 3'd4 && res[1]) |-> !cell_out[0]);

    p_dlat_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && mode == 3'd3 && res[1]) |-> (cell_out[0] == res[0]));

    p_jk_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && mode == 3'd2 && res == 2'b11 && !cfg_we)
        |=> (!glb_en || cell_out[0] != $past(cell_out[0])));

    p_dff_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && mode == 3'd1 && res[1] && !cfg_we)
        |=> (!glb_en || cell_out[0] == $past(res[0])));

    p_edge_single_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pls[0] && !cfg_we) |=> !edge_pls[0]);

    p_edge_single_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pls[1] && !cfg_we) |=> !edge_pls[1]);
endmodule

bind lut_pair_cell lut_pair_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .glb_en   (glb_en),
    .cfg_we   (cfg_we),
    .mode     (mode_q),
    .res      (cell_res),
    .edge_pls (edge_pls),
    .cell_out (cell_out)
);

// File: tb/tb_lut_pair_cell.sv
`timescale 1ns/1ps
module tb_lut_pair_cell;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       glb_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [5:0] cell_in = '0;
    logic [1:0] cell_out;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    lut_pair_cell dut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cell_in(cell_in),
        .cell_out(cell_out)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic set_ab(input logic a, input logic b);
        cell_in = {2'b00, b, 2'b00, a};
        #1;
    endtask

    task automatic t_reset;
        chk("R12 reset lower", cell_out[0], 1'b0);
        chk("R12 reset upper", cell_out[1], 1'b0);
    endtask

    task automatic t_lut;
        wr(0, 8'h96); wr(2, 8'h07); wr(4, 8'h00);
        for (int p = 0; p < 8; p++) begin
            cell_in[2:0] = 3'(p); #1;
            chk("R1 xor3", cell_out[0], ^3'(p));
        end
        wr(0, 8'hE8);
        for (int p = 0; p < 8; p++) begin
            cell_in[2:0] = 3'(p); #1;
            chk("R1 majority", cell_out[0], (p == 3 || p >= 5));
        end
    endtask

    task automatic t_mask;
        wr(0, 8'h01); wr(2, 8'h01);
        cell_in[2:0] = 3'b110; #1;
        chk("R2 masked not in0=0", cell_out[0], 1'b1);
        cell_in[2:0] = 3'b111; #1;
        chk("R2 masked not in0=1", cell_out[0], 1'b0);
        wr(2, 8'h07);
        cell_in[2:0] = 3'b110; #1;
        chk("R2 unmasked", cell_out[0], 1'b0);
    endtask

    task automatic t_sync;
        wr(0, 8'hAA); wr(2, 8'h0F);
        cell_in = '0; tick(4);
        cell_in[0] = 1'b1;
        tick(1); chk("R3 sync after 1 edge", cell_out[0], 1'b0);
        tick(1); chk("R3 sync after 2 edges", cell_out[0], 1'b1);
    endtask

    task automatic t_filter;
        wr(2, 8'h17);
        cell_in = '0; tick(8);
        chk("R4 filter idle", cell_out[0], 1'b0);
        cell_in[0] = 1'b1;
        tick(4); chk("R4 filter after 4 edges", cell_out[0], 1'b0);
        tick(1); chk("R4 filter after 5 edges", cell_out[0], 1'b1);
        cell_in[0] = 1'b0; tick(8);
        cell_in[0] = 1'b1; tick(1); cell_in[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk("R4 glitch blocked", cell_out[0], 1'b0);
            tick(1);
        end
    endtask

    task automatic t_edge;
        wr(2, 8'h27);
        cell_in = '0; tick(2);
        cell_in[0] = 1'b1; #1;
        chk("R5 rising pulse", cell_out[0], 1'b1);
        tick(1); chk("R5 rising pulse ends", cell_out[0], 1'b0);
        tick(2); chk("R5 no repeat", cell_out[0], 1'b0);
        wr(2, 8'h67); #1;
        chk("R5 falling idle", cell_out[0], 1'b0);
        cell_in[0] = 1'b0; #1;
        chk("R5 falling pulse", cell_out[0], 1'b1);
        tick(1); chk("R5 falling pulse ends", cell_out[0], 1'b0);
    endtask

    task automatic t_dff;
        wr(0, 8'hAA); wr(1, 8'hAA); wr(2, 8'h07); wr(3, 8'h07); wr(4, 8'h01);
        set_ab(1'b1, 1'b1);
        chk("R6 dff before edge", cell_out[0], 1'b0);
        tick(1); chk("R6 dff capture 1", cell_out[0], 1'b1);
        set_ab(1'b0, 1'b0); tick(1);
        chk("R6 dff hold", cell_out[0], 1'b1);
        set_ab(1'b0, 1'b1); tick(1);
        chk("R6 dff capture 0", cell_out[0], 1'b0);
    endtask

    task automatic t_jk;
        set_ab(1'b0, 1'b0);
        wr(4, 8'h02);
        set_ab(1'b1, 1'b0); tick(1); chk("R7 jk set", cell_out[0], 1'b1);
        set_ab(1'b0, 1'b0); tick(1); chk("R7 jk hold", cell_out[0], 1'b1);
        set_ab(1'b1, 1'b1); tick(1); chk("R7 jk toggle low", cell_out[0], 1'b0);
        tick(1); chk("R7 jk toggle high", cell_out[0], 1'b1);
        set_ab(1'b0, 1'b1); tick(1); chk("R7 jk clear", cell_out[0], 1'b0);
    endtask

    task automatic t_dlat;
        wr(4, 8'h03);
        set_ab(1'b1, 1'b1); chk("R8 latch transparent", cell_out[0], 1'b1);
        tick(1);
        set_ab(1'b0, 1'b0); chk("R8 latch hold", cell_out[0], 1'b1);
        set_ab(1'b0, 1'b1); chk("R8 latch follow 0", cell_out[0], 1'b0);
        tick(1);
        set_ab(1'b1, 1'b0); chk("R8 latch hold 0", cell_out[0], 1'b0);
    endtask

    task automatic t_sr;
        set_ab(1'b0, 1'b0);
        wr(4, 8'h04); tick(1);
        chk("R9 sr idle", cell_out[0], 1'b0);
        set_ab(1'b1, 1'b0); chk("R9 sr set", cell_out[0], 1'b1);
        tick(1);
        set_ab(1'b0, 1'b0); chk("R9 sr hold", cell_out[0], 1'b1);
        set_ab(1'b1, 1'b1); chk("R9 sr reset wins", cell_out[0], 1'b0);
        chk("R11 upper passes", cell_out[1], 1'b1);
        tick(1);
        set_ab(1'b0, 1'b0); chk("R9 sr held clear", cell_out[0], 1'b0);
        set_ab(1'b1, 1'b0); tick(1);
        set_ab(1'b0, 1'b0); chk("R9 sr set again", cell_out[0], 1'b1);
    endtask

    task automatic t_enable;
        glb_en = 1'b0; #1;
        chk("R10 disabled lower", cell_out[0], 1'b0);
        set_ab(1'b1, 1'b1);
        chk("R10 disabled upper", cell_out[1], 1'b0);
        tick(2);
        set_ab(1'b0, 1'b0);
        glb_en = 1'b1; #1;
        chk("R10 state cleared", cell_out[0], 1'b0);
    endtask

    task automatic t_ignore;
        wr(4, 8'h00);
        set_ab(1'b1, 1'b0);
        chk("R11 mode0 lower", cell_out[0], 1'b1);
        wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
        set_ab(1'b1, 1'b0);
        chk("R12 ignored lower", cell_out[0], 1'b1);
        chk("R12 ignored upper", cell_out[1], 1'b0);
        set_ab(1'b0, 1'b1);
        chk("R12 ignored lower 2", cell_out[0], 1'b0);
        chk("R11 upper mode0", cell_out[1], 1'b1);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        glb_en = 1'b1;
        t_lut();
        t_mask();
        t_sync();
        t_filter();
        t_edge();
        t_dff();
        t_jk();
        t_dlat();
        t_sr();
        t_enable();
        t_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule